// File: doc/BRIEF.md
# LPC Host SYNC Phase Monitor

This block watches the SYNC phase of a Low Pin Count bus cycle from the host side. The host cycle engine pulses `start` on the clock where the bus is handed over for SYNC, and gives the kind of cycle in progress. From the next clock on, the block samples the 4-bit LAD value on every clock. It tells wait states apart from final answers and counts clocks on which nobody drives the bus. When the phase ends, it returns exactly one result pulse: completion, DMA continue, DMA stop, error, or an abort request. On an abort request the cycle engine carries out the LFRAME# abort sequence, holding LFRAME# low for at least four clocks with LAD at 1111.

The rules for each cycle kind are applied while the phase runs. Ready-more is legal only on DMA. An error SYNC is illegal on firmware-hub cycles. On DMA, both ready and error also mean the peripheral has dropped its request. For bus-master cycles the host answers the SYNC itself. It drives long wait until its own side is ready, then drives ready for one clock. It never drives short wait.

Top module: `lpc_sync_monitor`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `busy`, `lad_oe` and every result output (`done`, `dma_more`, `dma_stop`, `sync_err`, `abort_req`, `serr`, `dreq_off`) are 0.
- R2: `start` high while idle latches `cyc_kind` (000 memory, 001 I/O, 010 DMA, 011 firmware hub, 100 bus master; 101 to 111 are handled as memory) and sets `busy`. LAD is first sampled on the next clock. Each result shows one clock after the LAD sample that caused it, and `busy` drops in that same cycle. A ready code (0000) on a memory, I/O or firmware-hub cycle gives `done`.
- R3: Short wait (0101) and long wait (0110) keep the phase open with no result and clear the no-response count. A run of long waits of any length is accepted.
- R4: LAD = 1111 counts as no response. The fourth consecutive no-response sample gives `abort_req`. Three in a row followed by a valid code do not abort.
- R5: Any code other than 0000, 0101, 0110, 1001, 1010 and 1111 gives `abort_req` on the clock after it is sampled. So does ready-more (1001) on a memory, I/O or firmware-hub cycle.
- R6: Error (1010) on a memory, I/O or DMA cycle gives `sync_err` together with a `serr` pulse.
- R7: On DMA, ready (0000) gives `dma_stop`, ready-more (1001) gives `dma_more`, and `dreq_off` pulses with `dma_stop` and with a DMA `sync_err`, but not with `dma_more`.
- R8: On a firmware-hub cycle, error (1010) gives `abort_req` with no `serr`.
- R9: On a bus-master cycle, `lad_oe` is high with `lad_out` = 0110 from the clock after `start` until the clock after `host_rdy` is sampled. Then `lad_out` = 0000 for one clock, and `done` follows one clock later. `lad_out` is never 0101 while `lad_oe` is high.
- R10: At most one of `done`, `dma_more`, `dma_stop`, `sync_err` and `abort_req` is high in any cycle, and each is a one-clock pulse.
- R11: `start` and changes of `cyc_kind` while `busy` have no effect on the running phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | SYNC phase begins (one clock) |
| cyc_kind | input | 3 | Kind of the cycle, latched at `start` |
| lad_in | input | 4 | LAD value sampled from the bus |
| host_rdy | input | 1 | Host side ready, bus-master cycles only |
| busy | output | 1 | SYNC phase in progress |
| lad_oe | output | 1 | Host drives LAD |
| lad_out | output | 4 | LAD value driven by the host |
| done | output | 1 | Cycle completed |
| dma_more | output | 1 | DMA transfer done, channel wants more |
| dma_stop | output | 1 | DMA transfer done, channel finished |
| sync_err | output | 1 | Cycle completed with error |
| abort_req | output | 1 | Request for an LFRAME# abort |
| serr | output | 1 | System-error report |
| dreq_off | output | 1 | DMA request de-asserted |

## Verification
Every peripheral result arrives exactly one clock after the LAD sample that decides it. The no-response abort arrives one clock after the fourth sample of 1111 in a row. The bench drives LAD on the falling edge and reads the outputs just after the rising edge that samples it, so each check looks at the only cycle in which the pulse can be high. On bus-master cycles `lad_out` is checked on every clock: long wait until the clock after `host_rdy`, ready for one clock, and `done` one clock after that. The sweep covers all sixteen LAD codes on all four peripheral kinds.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

    localparam int LAD_W = 4;

    localparam logic [LAD_W-1:0] SYNC_READY = 4'b0000;
    localparam logic [LAD_W-1:0] SYNC_SHORT = 4'b0101;
    localparam logic [LAD_W-1:0] SYNC_LONG  = 4'b0110;
    localparam logic [LAD_W-1:0] SYNC_MORE  = 4'b1001;
    localparam logic [LAD_W-1:0] SYNC_ERROR = 4'b1010;
    localparam logic [LAD_W-1:0] SYNC_FLOAT = 4'b1111;

    typedef enum logic [2:0] {
        CYC_MEM = 3'd0,
        CYC_IO  = 3'd1,
        CYC_DMA = 3'd2,
        CYC_FWH = 3'd3,
        CYC_BM  = 3'd4
    } cyc_kind_e;

    typedef enum logic [2:0] {
        VD_WAIT,
        VD_NORESP,
        VD_DONE,
        VD_MORE,
        VD_STOP,
        VD_ERR,
        VD_BAD
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PERIPH,
        ST_BM_WAIT,
        ST_BM_RDY
    } phase_e;

    typedef struct packed {
        logic abort;
        logic error;
        logic stop;
        logic more;
        logic done;
    } result_t;

    function automatic cyc_kind_e norm_kind(input logic [2:0] raw);
        if (raw > 3'd4) return CYC_MEM;
        return cyc_kind_e'(raw);
    endfunction

    function automatic verdict_e classify(input logic [LAD_W-1:0] code,
                                          input cyc_kind_e kind);
        verdict_e v;
        case (code)
            SYNC_READY: v = (kind == CYC_DMA) ? VD_STOP : VD_DONE;
            SYNC_SHORT,
            SYNC_LONG:  v = VD_WAIT;
            SYNC_MORE:  v = (kind == CYC_DMA) ? VD_MORE : VD_BAD;
            SYNC_ERROR: v = (kind == CYC_FWH) ? VD_BAD : VD_ERR;
            SYNC_FLOAT: v = VD_NORESP;
            default:    v = VD_BAD;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lpc_sync_decode.sv
module lpc_sync_decode
    import lpc_sync_pkg::*;
(
    input  logic [LAD_W-1:0] code,
    input  cyc_kind_e        kind,
    output verdict_e         verdict,
    output logic             drops_req
);
    always_comb begin
        verdict   = classify(code, kind);
        drops_req = (kind == CYC_DMA) && ((verdict == VD_STOP) || (verdict == VD_ERR));
    end
endmodule

// File: rtl/lpc_sync_timeout.sv
module lpc_sync_timeout #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = tick && !clr && (cnt == LAST);
endmodule

// File: rtl/lpc_sync_monitor.sv
module lpc_sync_monitor
    import lpc_sync_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] cyc_kind,
    input  logic [3:0] lad_in,
    input  logic       host_rdy,
    output logic       busy,
    output logic       lad_oe,
    output logic [3:0] lad_out,
    output logic       done,
    output logic       dma_more,
    output logic       dma_stop,
    output logic       sync_err,
    output logic       abort_req,
    output logic       serr,
    output logic       dreq_off
);
    phase_e    state_q, state_d;
    cyc_kind_e kind_q, kind_d;
    result_t   res_q, res_d;
    logic      serr_q, serr_d;
    logic      dreq_q, dreq_d;

    verdict_e  verdict;
    logic      drops_req;
    logic      tmr_clr, tmr_tick, tmr_expire;

    lpc_sync_decode u_decode (
        .code      (lad_in),
        .kind      (kind_q),
        .verdict   (verdict),
        .drops_req (drops_req)
    );

    assign tmr_tick = (state_q == ST_PERIPH) && (verdict == VD_NORESP);
    assign tmr_clr  = !tmr_tick;

    lpc_sync_timeout #(.LIMIT(TIMEOUT_CLKS)) u_timeout (
        .clk    (clk),
        .rst    (rst),
        .clr    (tmr_clr),
        .tick   (tmr_tick),
        .expire (tmr_expire)
    );

    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        res_d   = '0;
        serr_d  = 1'b0;
        dreq_d  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    kind_d  = norm_kind(cyc_kind);
                    state_d = (norm_kind(cyc_kind) == CYC_BM) ? ST_BM_WAIT : ST_PERIPH;
                end
            end
            ST_PERIPH: begin
                dreq_d = drops_req;
                case (verdict)
                    VD_WAIT: ;
                    VD_NORESP: begin
                        if (tmr_expire) begin
                            res_d.abort = 1'b1;
                            state_d     = ST_IDLE;
                        end
                    end
                    VD_DONE: begin
                        res_d.done = 1'b1;
                        state_d    = ST_IDLE;
                    end
                    VD_MORE: begin
                        res_d.more = 1'b1;
                        state_d    = ST_IDLE;
                    end
                    VD_STOP: begin
                        res_d.stop = 1'b1;
                        state_d    = ST_IDLE;
                    end
                    VD_ERR: begin
                        res_d.error = 1'b1;
                        serr_d      = 1'b1;
                        state_d     = ST_IDLE;
                    end
                    default: begin
                        res_d.abort = 1'b1;
                        state_d     = ST_IDLE;
                    end
                endcase
            end
            ST_BM_WAIT: begin
                if (host_rdy) state_d = ST_BM_RDY;
            end
            ST_BM_RDY: begin
                res_d.done = 1'b1;
                state_d    = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= CYC_MEM;
            res_q   <= '0;
            serr_q  <= 1'b0;
            dreq_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            res_q   <= res_d;
            serr_q  <= serr_d;
            dreq_q  <= dreq_d;
        end
    end

    always_comb begin
        lad_oe  = (state_q == ST_BM_WAIT) || (state_q == ST_BM_RDY);
        lad_out = (state_q == ST_BM_WAIT) ? SYNC_LONG : SYNC_READY;
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = res_q.done;
    assign dma_more  = res_q.more;
    assign dma_stop  = res_q.stop;
    assign sync_err  = res_q.error;
    assign abort_req = res_q.abort;
    assign serr      = serr_q;
    assign dreq_off  = dreq_q;
endmodule

// File: rtl/lpc_sync_monitor_chk.sv
module lpc_sync_monitor_chk #(
    parameter int TIMEOUT_CLKS = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [2:0] cyc_kind,
    input logic [3:0] lad_in,
    input logic       host_rdy,
    input logic       busy,
    input logic       lad_oe,
    input logic [3:0] lad_out,
    input logic       done,
    input logic       dma_more,
    input logic       dma_stop,
    input logic       sync_err,
    input logic       abort_req,
    input logic       serr,
    input logic       dreq_off
);
    localparam int RW = $clog2(TIMEOUT_CLKS + 2);

    logic [RW-1:0] idle_run;
    logic          kind_dma;
    logic          any_res;

    assign any_res = done | dma_more | dma_stop | sync_err | abort_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_run <= '0;
            kind_dma <= 1'b0;
        end else begin
            if (!busy && start) kind_dma <= (cyc_kind == 3'd2);
            if (busy && !lad_oe && lad_in == 4'hF && idle_run <= RW'(TIMEOUT_CLKS))
                idle_run <= idle_run + 1'b1;
            else
                idle_run <= '0;
        end
    end

    // R10
    results_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, dma_more, dma_stop, sync_err, abort_req}));

    // R10
    abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        abort_req |=> !abort_req);

    // R2
    result_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        any_res |-> ($past(busy) && !busy));

    // R4
    noresp_limit_chk: assert property (@(posedge clk) disable iff (rst)
        idle_run <= RW'(TIMEOUT_CLKS));

    // R4
    noresp_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_run == RW'(TIMEOUT_CLKS)) |-> abort_req);

    // R6
    serr_with_err_chk: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> serr);

    // R7
    more_only_dma_chk: assert property (@(posedge clk) disable iff (rst)
        dma_more |-> (kind_dma && !dreq_off));

    // R9
    no_short_drive_chk: assert property (@(posedge clk) disable iff (rst)
        lad_oe |-> (lad_out != 4'b0101));
endmodule

bind lpc_sync_monitor lpc_sync_monitor_chk #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cyc_kind  (cyc_kind),
    .lad_in    (lad_in),
    .host_rdy  (host_rdy),
    .busy      (busy),
    .lad_oe    (lad_oe),
    .lad_out   (lad_out),
    .done      (done),
    .dma_more  (dma_more),
    .dma_stop  (dma_stop),
    .sync_err  (sync_err),
    .abort_req (abort_req),
    .serr      (serr),
    .dreq_off  (dreq_off)
);

// File: tb/test_lpc_sync_monitor.sv
module test_lpc_sync_monitor;
    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [2:0] cyc_kind;
    logic [3:0] lad_in;
    logic       host_rdy;
    logic       busy, lad_oe;
    logic [3:0] lad_out;
    logic       done, dma_more, dma_stop, sync_err, abort_req, serr, dreq_off;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lpc_sync_monitor #(.TIMEOUT_CLKS(4)) i_lpc_sync_monitor (
        .clk(clk), .rst(rst), .start(start), .cyc_kind(cyc_kind), .lad_in(lad_in),
        .host_rdy(host_rdy), .busy(busy), .lad_oe(lad_oe), .lad_out(lad_out),
        .done(done), .dma_more(dma_more), .dma_stop(dma_stop), .sync_err(sync_err),
        .abort_req(abort_req), .serr(serr), .dreq_off(dreq_off)
    );

    // {abort, error, stop, more, done, serr, dreq_off}
    function automatic logic [6:0] outs();
        return {abort_req, sync_err, dma_stop, dma_more, done, serr, dreq_off};
    endfunction

    function automatic logic [6:0] expect_final(input logic [2:0] k, input logic [3:0] c);
        bit dma = (k == 3'd2);
        bit fwh = (k == 3'd3);
        case (c)
            4'b0000: return dma ? 7'b0010001 : 7'b0000100;
            4'b1001: return dma ? 7'b0001000 : 7'b1000000;
            4'b1010: return fwh ? 7'b1000000 : (dma ? 7'b0100011 : 7'b0100010);
            default: return 7'b1000000;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step(input logic st, input logic [2:0] k, input logic [3:0] lad,
                        input logic hr);
        @(negedge clk);
        start = st; cyc_kind = k; lad_in = lad; host_rdy = hr;
        @(posedge clk);
        #1;
    endtask

    task automatic check_outs(input string req, input logic [6:0] exp, input logic exp_busy);
        check(outs() == exp, req, "results", 16'(outs()), 16'(exp));
        check(busy == exp_busy, req, "busy", 16'(busy), 16'(exp_busy));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 0; cyc_kind = 0; lad_in = 4'hF; host_rdy = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 during reset
        check_outs("R1", 7'b0, 1'b0);
        check(lad_oe == 0, "R1", "lad_oe", 16'(lad_oe), 16'd0);
        step(0, 0, 4'hF, 0);
        rst = 1'b0;
        step(0, 0, 4'hF, 0);
        // R1 first clock after reset
        check_outs("R1", 7'b0, 1'b0);

        // Sweep every code on every peripheral kind (R2 R3 R4 R5 R6 R7 R8)
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 16; c++) begin
                step(1, 3'(k), 4'hF, 0);
                check_outs("R2", 7'b0, 1'b1);
                step(0, 3'(k), 4'(c), 0);
                if (c == 4'b0101 || c == 4'b0110) begin
                    check_outs("R3", 7'b0, 1'b1);
                    step(0, 3'(k), 4'b0000, 0);
                    check_outs("R3", expect_final(3'(k), 4'b0000), 1'b0);
                end else if (c == 4'hF) begin
                    step(0, 3'(k), 4'hF, 0);
                    step(0, 3'(k), 4'hF, 0);
                    check_outs("R4", 7'b0, 1'b1);
                    step(0, 3'(k), 4'hF, 0);
                    check_outs("R4", 7'b1000000, 1'b0);
                end else if (c == 4'b1010) begin
                    check_outs(k == 3 ? "R8" : "R6", expect_final(3'(k), 4'(c)), 1'b0);
                end else if (c == 4'b0000 || c == 4'b1001) begin
                    check_outs(k == 2 ? "R7" : (c == 0 ? "R2" : "R5"),
                               expect_final(3'(k), 4'(c)), 1'b0);
                end else begin
                    check_outs("R5", expect_final(3'(k), 4'(c)), 1'b0);
                end
                step(0, 3'(k), 4'hF, 0);
                // R10 pulse lasts one clock
                check_outs("R10", 7'b0, 1'b0);
            end
        end

        // R4: three no-response samples, a wait, three more, then ready
        step(1, 3'd1, 4'hF, 0);
        for (int i = 0; i < 3; i++) step(0, 3'd1, 4'hF, 0);
        step(0, 3'd1, 4'b0101, 0);
        for (int i = 0; i < 3; i++) step(0, 3'd1, 4'hF, 0);
        check_outs("R4", 7'b0, 1'b1);
        step(0, 3'd1, 4'b0000, 0);
        check_outs("R4", 7'b0000100, 1'b0);

        // R3: long run of long waits
        step(1, 3'd0, 4'hF, 0);
        for (int i = 0; i < 300; i++) step(0, 3'd0, 4'b0110, 0);
        check_outs("R3", 7'b0, 1'b1);
        step(0, 3'd0, 4'b0000, 0);
        check_outs("R3", 7'b0000100, 1'b0);

        // R2: reserved kind 111 behaves as memory
        step(1, 3'd7, 4'hF, 0);
        step(0, 3'd7, 4'b1001, 0);
        check_outs("R2", 7'b1000000, 1'b0);

        // R11: kind latched; start while busy ignored
        step(1, 3'd2, 4'hF, 0);
        step(1, 3'd4, 4'b0110, 0);
        check(lad_oe == 0, "R11", "lad_oe after start while busy", 16'(lad_oe), 16'd0);
        step(0, 3'd0, 4'b1001, 0);
        check_outs("R11", 7'b0001000, 1'b0);

        // R9: bus-master cycle
        step(1, 3'd4, 4'hF, 0);
        for (int i = 0; i < 5; i++) begin
            check(lad_oe == 1 && lad_out == 4'b0110, "R9", "long wait drive",
                  16'({lad_oe, lad_out}), 16'b10110);
            check_outs("R9", 7'b0, 1'b1);
            step(0, 3'd4, 4'hF, (i == 4));
        end
        check(lad_oe == 1 && lad_out == 4'b0000, "R9", "ready drive",
              16'({lad_oe, lad_out}), 16'b10000);
        check_outs("R9", 7'b0, 1'b1);
        step(0, 3'd4, 4'hF, 0);
        check(lad_oe == 0, "R9", "release", 16'(lad_oe), 16'd0);
        check_outs("R9", 7'b0000100, 1'b0);
        step(0, 3'd4, 4'hF, 0);
        check_outs("R10", 7'b0, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule